// File: doc/BRIEF.md
# Dual-Port RAM with Busy Arbitration

This block is a synchronous memory with two symmetric ports, left and right. Each port has its own enable, write select, output enable, address, write data, read data and a read-valid flag. The read-valid flag stands in for a tri-stated data bus: when it is low, the port's read data is to be treated as undriven. The two ports may read or write any word at the same time.

When both ports are enabled, point at the same word and at least one of them is writing, the block picks one port and pulls the other port's active-low busy line. A port whose busy is low has its write dropped, while the winning port's access goes ahead. The parameter `IS_MASTER` picks the variant. A master instance computes busy itself and drives it out. A slave instance takes busy from its input pins and applies the same write block, so several slaves can follow one master to build a wider word. In a slave, the busy outputs simply repeat the inputs.

Top module: `dpr_busy_arb`

## Requirements
- R1: Each port reads or writes any address with no dependence on the other port when the two addresses differ. A read started in one cycle presents the stored word on that port's read data after the next rising edge.
- R2: A word written through one port is returned by a read of that address on the other port issued in the following cycle.
- R3 (master): a busy output is low only while both ports are enabled, their addresses are equal and at least one of them writes. Exactly one of the two busy outputs is low in such a cycle. A read on both ports to the same address leaves both busy outputs high.
- R4: A write on a port whose effective busy is low does not change memory. The other port's write to that word in the same cycle takes effect.
- R5 (master): when neither port held the contested address in the previous cycle, or both did, the left port wins and the right busy goes low.
- R6 (master): a port that was enabled at the contested address in the previous cycle while the other was not wins the contest. While the contest continues at an unchanged address, the same port keeps winning.
- R7: A port with its enable low performs no write, its read-valid is low after the next edge, and it causes no busy.
- R8: A read with output enable low leaves read-valid low after the next edge.
- R9: During a write cycle the writing port's read-valid is low after the next edge, whatever its output enable.
- R10 (slave, `IS_MASTER`=0): each port's write is blocked when its busy input is low, and each busy output equals the matching busy input.
- R11: While reset is low, both read-valid outputs are low and, in a master, both busy outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left port write select (1 = write) |
| l_oe | input | 1 | Left port output enable |
| l_addr | input | ADDR_W | Left port word address |
| l_wdata | input | DATA_W | Left port write data |
| l_rdata | output | DATA_W | Left port read data |
| l_rvalid | output | 1 | Left read data driven |
| l_busy_n_i | input | 1 | Left busy input, used in slave mode, active low |
| l_busy_n_o | output | 1 | Left busy output, active low |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right port write select (1 = write) |
| r_oe | input | 1 | Right port output enable |
| r_addr | input | ADDR_W | Right port word address |
| r_wdata | input | DATA_W | Right port write data |
| r_rdata | output | DATA_W | Right port read data |
| r_rvalid | output | 1 | Right read data driven |
| r_busy_n_i | input | 1 | Right busy input, used in slave mode, active low |
| r_busy_n_o | output | 1 | Right busy output, active low |

## Verification
The properties assume that the port inputs are stable around each rising edge and that no port input is X once reset has been released. The priority property also assumes that the contested address stays unchanged across the cycles it compares. The bench changes every input only at the falling edge. Before any read, it fills every word of both instances, so read data is never undefined. Its random phase limits addresses to four words and draws the slave busy inputs at random, which makes same-word clashes, repeated clashes and blocked slave writes frequent.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
   typedef enum logic {
      WIN_LEFT  = 1'b0,
      WIN_RIGHT = 1'b1
   } dpr_side_e;
endpackage

// File: rtl/dpr_arbiter.sv
// Same-word contention detector with previous-cycle ownership memory.
module dpr_arbiter
   import dpr_pkg::*;
#(
   parameter int ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_en,
   input  logic              l_wr,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              r_en,
   input  logic              r_wr,
   input  logic [ADDR_W-1:0] r_addr,
   output logic              l_busy_n,
   output logic              r_busy_n
);
   logic              clash;
   logic              l_held, r_held, keep;
   dpr_side_e         win;
   logic              prev_clash;
   logic [ADDR_W-1:0] prev_clash_addr;
   dpr_side_e         prev_win;
   logic              l_seen, r_seen;
   logic [ADDR_W-1:0] l_last, r_last;

   assign clash  = l_en & r_en & (l_wr | r_wr) & (l_addr == r_addr);
   assign l_held = l_seen & (l_last == l_addr);
   assign r_held = r_seen & (r_last == r_addr);
   assign keep   = prev_clash & (prev_clash_addr == l_addr);

   always_comb begin
      if (keep)                 win = prev_win;
      else if (r_held & ~l_held) win = WIN_RIGHT;
      else                       win = WIN_LEFT;
   end

   assign l_busy_n = ~(clash & (win == WIN_RIGHT));
   assign r_busy_n = ~(clash & (win == WIN_LEFT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_clash      <= 1'b0;
         prev_clash_addr <= '0;
         prev_win        <= WIN_LEFT;
         l_seen          <= 1'b0;
         r_seen          <= 1'b0;
         l_last          <= '0;
         r_last          <= '0;
      end else begin
         prev_clash      <= clash;
         prev_clash_addr <= l_addr;
         prev_win        <= win;
         l_seen          <= l_en;
         r_seen          <= r_en;
         l_last          <= l_addr;
         r_last          <= r_addr;
      end
   end
endmodule

// File: rtl/dpr_storage.sv
// Word array with two write and two registered read paths.
module dpr_storage #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              a_we,
   input  logic              a_re,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              b_we,
   input  logic              b_re,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata
);
   logic [DATA_W-1:0] words [DEPTH];

   // Port a is written last so it prevails if both writes reach one word.
   always_ff @(posedge clk) begin
      if (b_we) words[b_addr] <= b_wdata;
      if (a_we) words[a_addr] <= a_wdata;
   end

   always_ff @(posedge clk) begin
      if (a_re) a_rdata <= words[a_addr];
      if (b_re) b_rdata <= words[b_addr];
   end
endmodule

// File: rtl/dpr_outctl.sv
// Per-port flag telling whether read data counts as driven.
module dpr_outctl (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic wr,
   input  logic oe,
   output logic valid
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid <= 1'b0;
      else        valid <= en & ~wr & oe;
   end
endmodule

// File: rtl/dpr_busy_arb.sv
module dpr_busy_arb #(
   parameter int ADDR_W    = 5,
   parameter int DATA_W    = 8,
   parameter bit IS_MASTER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_en,
   input  logic              l_wr,
   input  logic              l_oe,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   output logic              l_rvalid,
   input  logic              l_busy_n_i,
   output logic              l_busy_n_o,
   input  logic              r_en,
   input  logic              r_wr,
   input  logic              r_oe,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata,
   output logic              r_rvalid,
   input  logic              r_busy_n_i,
   output logic              r_busy_n_o
);
   localparam int DEPTH = 1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("dpr_busy_arb: ADDR_W out of range 1..12");
   end
   if (DATA_W < 1 || DATA_W > 256) begin : g_bad_data
      $error("dpr_busy_arb: DATA_W out of range 1..256");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("dpr_busy_arb: depth below two words");
   end

   logic l_gate_n, r_gate_n;

   if (IS_MASTER) begin : g_master
      logic unused_busy_in;
      assign unused_busy_in = l_busy_n_i ^ r_busy_n_i;
      dpr_arbiter #(.ADDR_W(ADDR_W)) u_arb (
         .clk      (clk),
         .rst_n    (rst_n),
         .l_en     (l_en),
         .l_wr     (l_wr),
         .l_addr   (l_addr),
         .r_en     (r_en),
         .r_wr     (r_wr),
         .r_addr   (r_addr),
         .l_busy_n (l_gate_n),
         .r_busy_n (r_gate_n)
      );
   end else begin : g_slave
      assign l_gate_n = l_busy_n_i;
      assign r_gate_n = r_busy_n_i;
   end

   assign l_busy_n_o = l_gate_n;
   assign r_busy_n_o = r_gate_n;

   dpr_storage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk     (clk),
      .a_we    (l_en & l_wr & l_gate_n),
      .a_re    (l_en & ~l_wr),
      .a_addr  (l_addr),
      .a_wdata (l_wdata),
      .a_rdata (l_rdata),
      .b_we    (r_en & r_wr & r_gate_n),
      .b_re    (r_en & ~r_wr),
      .b_addr  (r_addr),
      .b_wdata (r_wdata),
      .b_rdata (r_rdata)
   );

   dpr_outctl u_l_out (
      .clk (clk), .rst_n (rst_n), .en (l_en), .wr (l_wr), .oe (l_oe), .valid (l_rvalid)
   );
   dpr_outctl u_r_out (
      .clk (clk), .rst_n (rst_n), .en (r_en), .wr (r_wr), .oe (r_oe), .valid (r_rvalid)
   );
endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
   parameter int ADDR_W    = 5,
   parameter bit IS_MASTER = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              l_en,
   input logic              l_wr,
   input logic              l_oe,
   input logic [ADDR_W-1:0] l_addr,
   input logic              l_rvalid,
   input logic              l_busy_n_o,
   input logic              r_en,
   input logic              r_wr,
   input logic              r_oe,
   input logic [ADDR_W-1:0] r_addr,
   input logic              r_rvalid,
   input logic              r_busy_n_o
);
   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   AST_L_WRITE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (l_en && l_wr) |=> !l_rvalid); // R9
   AST_R_WRITE_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (r_en && r_wr) |=> !r_rvalid); // R9
   AST_L_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      !l_oe |=> !l_rvalid); // R8
   AST_R_OE_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      !r_oe |=> !r_rvalid); // R8
   AST_L_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !l_en |=> !l_rvalid); // R7
   AST_L_READ_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (l_en && !l_wr && l_oe) |=> l_rvalid); // R1

   if (IS_MASTER) begin : g_master_props
      logic clash;
      assign clash = l_en && r_en && (l_wr || r_wr) && (l_addr == r_addr);

      AST_BUSY_NEEDS_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
         (!l_busy_n_o || !r_busy_n_o) |-> clash); // R3
      AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
         clash |-> ($countones({l_busy_n_o, r_busy_n_o}) == 1)); // R3
      AST_HOLDER_KEEPS_L: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && clash && $past(clash) && $stable(l_addr) && $past(r_busy_n_o) && !$past(l_busy_n_o))
         |-> (r_busy_n_o && !l_busy_n_o)); // R6
      AST_HOLDER_KEEPS_R: assert property (@(posedge clk) disable iff (!rst_n)
         (armed && clash && $past(clash) && $stable(l_addr) && $past(l_busy_n_o) && !$past(r_busy_n_o))
         |-> (l_busy_n_o && !r_busy_n_o)); // R6
   end
endmodule

bind dpr_busy_arb dpr_checker #(.ADDR_W(ADDR_W), .IS_MASTER(IS_MASTER)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .l_en       (l_en),
   .l_wr       (l_wr),
   .l_oe       (l_oe),
   .l_addr     (l_addr),
   .l_rvalid   (l_rvalid),
   .l_busy_n_o (l_busy_n_o),
   .r_en       (r_en),
   .r_wr       (r_wr),
   .r_oe       (r_oe),
   .r_addr     (r_addr),
   .r_rvalid   (r_rvalid),
   .r_busy_n_o (r_busy_n_o)
);

// File: tb/dpr_busy_arb_tb.sv
module dpr_busy_arb_tb;
   localparam int AW    = 5;
   localparam int DW    = 8;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic          l_en = 0, l_wr = 0, l_oe = 0, r_en = 0, r_wr = 0, r_oe = 0;
   logic [AW-1:0] l_addr = '0, r_addr = '0;
   logic [DW-1:0] l_wdata = '0, r_wdata = '0;
   logic          sb_l = 1'b1, sb_r = 1'b1;

   logic [DW-1:0] m_lrd, m_rrd, s_lrd, s_rrd;
   logic          m_lv, m_rv, s_lv, s_rv, m_lb, m_rb, s_lb, s_rb;

   dpr_busy_arb #(.ADDR_W(AW), .DATA_W(DW), .IS_MASTER(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
      .l_rdata(m_lrd), .l_rvalid(m_lv), .l_busy_n_i(1'b1), .l_busy_n_o(m_lb),
      .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
      .r_rdata(m_rrd), .r_rvalid(m_rv), .r_busy_n_i(1'b1), .r_busy_n_o(m_rb));

   dpr_busy_arb #(.ADDR_W(AW), .DATA_W(DW), .IS_MASTER(1'b0)) u_dut_slave (
      .clk(clk), .rst_n(rst_n),
      .l_en(l_en), .l_wr(l_wr), .l_oe(l_oe), .l_addr(l_addr), .l_wdata(l_wdata),
      .l_rdata(s_lrd), .l_rvalid(s_lv), .l_busy_n_i(sb_l), .l_busy_n_o(s_lb),
      .r_en(r_en), .r_wr(r_wr), .r_oe(r_oe), .r_addr(r_addr), .r_wdata(r_wdata),
      .r_rdata(s_rrd), .r_rvalid(s_rv), .r_busy_n_i(sb_r), .r_busy_n_o(s_rb));

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference state
   int m_mem [DEPTH];
   int s_mem [DEPTH];
   bit p_clash = 0, p_len = 0, p_ren = 0;
   int p_caddr = 0, p_laddr = 0, p_raddr = 0;
   int p_win = 0;           // 0 left won, 1 right won
   bit e_lb, e_rb, cur_clash;
   int cur_win;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic setl(input bit en, input bit wr, input bit oe, input int a, input int d);
      l_en = en; l_wr = wr; l_oe = oe; l_addr = AW'(a); l_wdata = DW'(d);
   endtask
   task automatic setr(input bit en, input bit wr, input bit oe, input int a, input int d);
      r_en = en; r_wr = wr; r_oe = oe; r_addr = AW'(a); r_wdata = DW'(d);
   endtask

   // One clock of stimulus: inputs are already set at a falling edge.
   task automatic cycle(input string tag);
      bit l_held, r_held, lv, rv;
      int la, ra, ld, rd, sld, srd;
      #1;
      la = int'(l_addr); ra = int'(r_addr);
      cur_clash = l_en && r_en && (l_wr || r_wr) && (la == ra);
      l_held = p_len && (p_laddr == la);
      r_held = p_ren && (p_raddr == ra);
      if (p_clash && p_caddr == la) cur_win = p_win;
      else if (r_held && !l_held)   cur_win = 1;
      else                          cur_win = 0;
      e_lb = !(cur_clash && cur_win == 1);
      e_rb = !(cur_clash && cur_win == 0);
      chk(m_lb == e_lb, {"R3 ", tag}, "left busy_n", int'(m_lb), int'(e_lb));
      chk(m_rb == e_rb, {"R3 ", tag}, "right busy_n", int'(m_rb), int'(e_rb));
      chk(s_lb == sb_l && s_rb == sb_r, "R10", "slave busy mirror",
          int'({s_lb, s_rb}), int'({sb_l, sb_r}));
      @(posedge clk);
      lv = l_en && !l_wr && l_oe;
      rv = r_en && !r_wr && r_oe;
      ld = m_mem[la]; rd = m_mem[ra]; sld = s_mem[la]; srd = s_mem[ra];
      if (r_en && r_wr && e_rb) m_mem[ra] = int'(r_wdata);
      if (l_en && l_wr && e_lb) m_mem[la] = int'(l_wdata);
      if (r_en && r_wr && sb_r) s_mem[ra] = int'(r_wdata);
      if (l_en && l_wr && sb_l) s_mem[la] = int'(l_wdata);
      p_clash = cur_clash; p_caddr = la; p_win = cur_win;
      p_len = l_en; p_laddr = la; p_ren = r_en; p_raddr = ra;
      #1;
      chk(m_lv == lv && s_lv == lv, tag, "left rvalid", int'({m_lv, s_lv}), int'({lv, lv}));
      chk(m_rv == rv && s_rv == rv, tag, "right rvalid", int'({m_rv, s_rv}), int'({rv, rv}));
      if (lv) begin
         chk(int'(m_lrd) == ld, tag, "left rdata", int'(m_lrd), ld);
         chk(int'(s_lrd) == sld, tag, "slave left rdata", int'(s_lrd), sld);
      end
      if (rv) begin
         chk(int'(m_rrd) == rd, tag, "right rdata", int'(m_rrd), rd);
         chk(int'(s_rrd) == srd, tag, "slave right rdata", int'(s_rrd), srd);
      end
      @(negedge clk);
   endtask

   task automatic idle();
      setl(0, 0, 0, 0, 0); setr(0, 0, 0, 0, 0);
   endtask

   initial begin
      #(10 * 200000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R11: reset state
      chk(!m_lv && !m_rv && !s_lv && !s_rv, "R11", "rvalid in reset",
          int'({m_lv, m_rv, s_lv, s_rv}), 0);
      chk(m_lb && m_rb, "R11", "busy_n in reset", int'({m_lb, m_rb}), 3);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: fill from both ports at distinct addresses in the same cycle
      for (int i = 0; i < DEPTH / 2; i++) begin
         setl(1, 1, 1, i, 3 * i + 1);
         setr(1, 1, 1, i + DEPTH / 2, 200 - i);
         cycle("R1");
      end
      // R1: simultaneous reads at distinct addresses
      for (int i = 0; i < 4; i++) begin
         setl(1, 0, 1, i, 0);
         setr(1, 0, 1, DEPTH - 1 - i, 0);
         cycle("R1");
      end

      // R2: write left, read right next cycle
      setl(1, 1, 0, 5, 8'hA5); setr(0, 0, 0, 0, 0); cycle("R2");
      setl(0, 0, 0, 0, 0);     setr(1, 0, 1, 5, 0); cycle("R2");

      // R3: read-read on one word gives no busy
      setl(1, 0, 1, 7, 0); setr(1, 0, 1, 7, 0); cycle("R3");
      idle(); cycle("R3");

      // R5, R4: fresh same-word write by both, left wins
      setl(1, 1, 0, 9, 8'h11); setr(1, 1, 0, 9, 8'h22); cycle("R5");
      idle(); cycle("R5");
      setl(1, 0, 1, 9, 0); cycle("R4");

      // R6, R4: right holds word 12, left arrives and loses its write
      setl(0, 0, 0, 0, 0);     setr(1, 0, 1, 12, 0); cycle("R6");
      setl(1, 1, 0, 12, 8'h33); setr(1, 0, 1, 12, 0); cycle("R6");
      setl(1, 1, 0, 12, 8'h44); setr(1, 1, 0, 12, 8'h55); cycle("R6");
      idle(); cycle("R6");
      setl(1, 0, 1, 12, 0); cycle("R4");

      // R7: disabled port writes nothing and raises no busy
      setl(0, 1, 1, 3, 8'hEE); setr(1, 1, 0, 3, 8'h66); cycle("R7");
      setl(1, 0, 1, 3, 0); setr(0, 0, 1, 3, 0); cycle("R7");

      // R8: read with output enable low
      setl(1, 0, 0, 4, 0); setr(1, 0, 0, 20, 0); cycle("R8");
      // R9: write with output enable high keeps output undriven
      setl(1, 1, 1, 6, 8'h77); setr(1, 1, 1, 21, 8'h78); cycle("R9");

      // R10: slave blocks left write on low busy input
      sb_l = 1'b0;
      setl(1, 1, 0, 15, 8'h99); setr(0, 0, 0, 0, 0); cycle("R10");
      sb_l = 1'b1;
      setl(1, 0, 1, 15, 0); cycle("R10");
      sb_r = 1'b0;
      setl(0, 0, 0, 0, 0); setr(1, 1, 0, 16, 8'h5A); cycle("R10");
      sb_r = 1'b1;
      setr(1, 0, 1, 16, 0); cycle("R10");

      // R4: random traffic on four words
      for (int n = 0; n < 600; n++) begin
         setl($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0,
              $urandom_range(0, 3), $urandom_range(0, 255));
         setr($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1, $urandom_range(0, 3) != 0,
              $urandom_range(0, 3), $urandom_range(0, 255));
         sb_l = $urandom_range(0, 3) != 0;
         sb_r = $urandom_range(0, 3) != 0;
         cycle("R4");
      end
      sb_l = 1'b1; sb_r = 1'b1;
      idle(); cycle("R4");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule